// File: doc/BRIEF.md
# AXI Read Data Width Splitter

This block sits on the read-data channel between a wide upstream source and a narrower downstream consumer. It accepts one wide beat at a time and hands it out as a fixed number of narrow beats. The number of narrow beats per wide beat is the ratio of the two data widths, which must be a power of two of at least two.

When a wide beat is accepted, the block copies its payload, transaction ID, two-bit response code and final-beat marker into an internal holding stage. Every narrow beat is built from that copy, so the upstream source can drop valid or change its bus straight after the handshake. Narrow beats leave in ascending bit order, starting with the least significant slice. The upstream side is ready again in the same cycle that the last slice is taken downstream, so a stream of wide beats produces narrow beats with no idle cycle between them.

Address channels, the write path, burst-length rewriting and unaligned start offsets are handled elsewhere.

Top module: `rds_top`

## Requirements
- R1: After reset `m_valid` is low, `m_last` is low and `s_ready` is high.
- R2: Each accepted wide beat yields exactly WIDE_W/NARROW_W narrow beats. Narrow beat k carries bits [k*NARROW_W +: NARROW_W] of the wide word, for k = 0 up to the final slice.
- R3: `m_id` equals the ID of the accepted wide beat on every narrow beat taken from it.
- R4: `m_resp` equals the response code of the accepted wide beat on every narrow beat taken from it.
- R5: `m_last` is high only on the final narrow beat of a wide beat whose last flag was set. It is low on every other narrow beat.
- R6: Once a wide beat has been accepted, changes on `s_data`, `s_id`, `s_resp` and `s_last` have no effect on the narrow beats taken from it.
- R7: `s_ready` is high exactly when no narrow beat is pending, or when the final slice is being accepted downstream in that cycle. In the second case the next wide beat is taken with no idle cycle.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data`, `m_id`, `m_resp` and `m_last` stay unchanged into the next cycle.
- R9: The slice position moves forward only on a downstream handshake. `m_valid` is high exactly while a narrow beat is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Wide beat offered |
| s_ready | output | 1 | Wide beat can be taken |
| s_data | input | WIDE_W | Wide read payload |
| s_id | input | ID_W | Wide beat transaction ID |
| s_resp | input | 2 | Wide beat response code |
| s_last | input | 1 | Wide beat ends its burst |
| m_valid | output | 1 | Narrow beat offered |
| m_ready | input | 1 | Downstream takes narrow beat |
| m_data | output | NARROW_W | Narrow read payload |
| m_id | output | ID_W | Narrow beat transaction ID |
| m_resp | output | 2 | Narrow beat response code |
| m_last | output | 1 | Narrow beat ends the burst |

## Verification
A wide handshake at a clock edge shows up as the first narrow beat right after that edge, because only the holding stage lies between input and output. `s_ready` follows `m_ready` in the same cycle, with no register in between. The bench sets the inputs just after the falling edge. It waits one time unit, then reads the outputs and works out which handshakes the next rising edge will complete. Expected narrow beats go into a queue when the wide handshake is seen and come out when the narrow handshake is seen. Every cycle the bench also compares `s_ready`, `m_valid` and the stall stability against the model.

// File: rtl/rds_pkg.sv
// Shared types for the read-data width splitter.
// Assumes nothing beyond the fixed two-bit response width.
package rds_pkg;
    localparam int RESP_W = 2;
    typedef logic [RESP_W-1:0] resp_t;
endpackage

// File: rtl/rds_hold.sv
// Holding stage: copies one accepted wide beat and its sideband fields.
// Keeps them until the final slice is taken downstream.
// Assumes load and drop are never high together. The top module gates drop.
module rds_hold
    import rds_pkg::*;
#(
    parameter int DW = 64,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          drop,
    input  logic [DW-1:0] in_data,
    input  logic [IW-1:0] in_id,
    input  resp_t         in_resp,
    input  logic          in_last,
    output logic          full,
    output logic [DW-1:0] h_data,
    output logic [IW-1:0] h_id,
    output resp_t         h_resp,
    output logic          h_last
);
    // Capture on load; empty on reset or when the final slice leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            h_data <= '0;
            h_id   <= '0;
            h_resp <= '0;
            h_last <= 1'b0;
        end else if (load) begin
            full   <= 1'b1;
            h_data <= in_data;
            h_id   <= in_id;
            h_resp <= in_resp;
            h_last <= in_last;
        end else if (drop) begin
            full   <= 1'b0;
        end
    end

    // R1: the stage is empty in the cycle after reset.
    a_r1_empty_after_reset: assert property (@(posedge clk) !rst_n |=> !full);
    // R6: held contents change only on a new load.
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(h_data) && $stable(h_id) && $stable(h_resp) && $stable(h_last));
endmodule

// File: rtl/rds_slice_ctr.sv
// Slice position counter: points at the next narrow slice to send.
// Assumes RATIO is a power of two and at least 2.
module rds_slice_ctr #(
    parameter int RATIO = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    output logic [IDX_W-1:0] idx,
    output logic             at_final
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RATIO - 1);

    // Flags the final slice of the held beat.
    always_comb at_final = (idx == LAST_IDX);

    // Restart on load, step on a downstream handshake, wrap after the final slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (load) begin
            idx <= '0;
        end else if (adv) begin
            idx <= at_final ? '0 : idx + 1'b1;
        end
    end

    // R9: the position holds unless a handshake or a load occurs.
    a_r9_idx_moves_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        !(load || adv) |=> $stable(idx));
endmodule

// File: rtl/rds_slice_sel.sv
// Slice selector: picks one narrow slice of the held wide word.
// The least significant slice has index 0.
// Assumes WW is an exact multiple of NW.
module rds_slice_sel #(
    parameter int WW    = 64,
    parameter int NW    = 32,
    parameter int RATIO = 2,
    parameter int IDX_W = 1
) (
    input  logic [WW-1:0]    wide,
    input  logic [IDX_W-1:0] idx,
    output logic [NW-1:0]    slice
);
    logic [NW-1:0] parts [RATIO];

    // Split the wide word into its narrow parts.
    for (genvar g = 0; g < RATIO; g++) begin : g_part
        assign parts[g] = wide[g*NW +: NW];
    end

    // Route the indexed part to the output.
    always_comb slice = parts[idx];
endmodule

// File: rtl/rds_top.sv
// Read-data width splitter top.
// Takes one wide beat into the holding stage and sends it out as RATIO narrow beats.
// Assumes WIDE_W / NARROW_W is a power of two and at least 2.
module rds_top
    import rds_pkg::*;
#(
    parameter int WIDE_W   = 64,
    parameter int NARROW_W = 32,
    parameter int ID_W     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [WIDE_W-1:0]   s_data,
    input  logic [ID_W-1:0]     s_id,
    input  logic [1:0]          s_resp,
    input  logic                s_last,
    output logic                m_valid,
    input  logic                m_ready,
    output logic [NARROW_W-1:0] m_data,
    output logic [ID_W-1:0]     m_id,
    output logic [1:0]          m_resp,
    output logic                m_last
);
    localparam int RATIO = WIDE_W / NARROW_W;
    localparam int IDX_W = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic             full, h_last, at_final, load, m_hs, drop;
    logic [WIDE_W-1:0] h_data;
    logic [ID_W-1:0]  h_id;
    resp_t            h_resp;
    logic [IDX_W-1:0] idx;

    // Handshake decode and upstream ready.
    always_comb begin
        m_hs    = full && m_ready;
        s_ready = !full || (m_ready && at_final);
        load    = s_valid && s_ready;
        drop    = m_hs && at_final && !load;
    end

    rds_hold #(.DW(WIDE_W), .IW(ID_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(load), .drop(drop),
        .in_data(s_data), .in_id(s_id), .in_resp(resp_t'(s_resp)), .in_last(s_last),
        .full(full), .h_data(h_data), .h_id(h_id), .h_resp(h_resp), .h_last(h_last)
    );

    rds_slice_ctr #(.RATIO(RATIO), .IDX_W(IDX_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(m_hs),
        .idx(idx), .at_final(at_final)
    );

    rds_slice_sel #(.WW(WIDE_W), .NW(NARROW_W), .RATIO(RATIO), .IDX_W(IDX_W)) u_sel (
        .wide(h_data), .idx(idx), .slice(m_data)
    );

    // Narrow-side sideband fields come from the held copy.
    always_comb begin
        m_valid = full;
        m_id    = h_id;
        m_resp  = h_resp;
        m_last  = h_last && at_final && full;
    end

    // R8: a stalled narrow beat stays unchanged.
    a_r8_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_id)
                                && $stable(m_resp) && $stable(m_last));
    // R7: upstream ready only when empty or the final slice is leaving.
    a_r7_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !m_valid || (m_ready && at_final));
    // R5: the last marker only with a valid final slice.
    a_r5_last_on_final: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid && at_final);
    // R7: a final-slice handshake with a new wide beat keeps output valid.
    a_r7_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_ready && at_final && s_valid |=> m_valid && idx == '0);
endmodule

// File: tb/rds_top_test.sv
module rds_top_test;
    localparam int WW = 64, NW = 32, IW = 4, RATIO = WW / NW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b0;
    logic [WW-1:0] s_data = '0;
    logic [IW-1:0] s_id = '0;
    logic [1:0] s_resp = '0;
    logic s_ready, m_valid, m_last;
    logic [NW-1:0] m_data;
    logic [IW-1:0] m_id;
    logic [1:0] m_resp;

    always #10 clk = ~clk;

    rds_top #(.WIDE_W(WW), .NARROW_W(NW), .ID_W(IW)) uut (.*);

    typedef struct packed {
        logic [NW-1:0] data; logic [IW-1:0] id; logic [1:0] resp; logic last; logic fin;
    } exp_t;
    exp_t q[$];
    int errors = 0, checks = 0;
    bit done = 0;

    function automatic logic [NW-1:0] slice_of(logic [WW-1:0] w, int k);
        return w[k*NW +: NW];
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic pv, pl; logic [NW-1:0] pd; logic [IW-1:0] pid; logic [1:0] pr; logic pstall;

    // Sample the outputs, judge the coming handshakes, update the model.
    task automatic observe();
        #1;
        chk("R9 valid", m_valid, q.size() != 0);
        if (pstall) begin
            chk("R8 stall", {m_valid, m_data, m_id, m_resp, m_last}, {pv, pd, pid, pr, pl});
        end
        if (q.size() != 0) begin
            chk("R2 data", m_data, q[0].data);
            chk("R3 id", m_id, q[0].id);
            chk("R4 resp", m_resp, q[0].resp);
            chk("R5 last", m_last, q[0].last);
            chk("R7 ready", s_ready, m_ready && q[0].fin);
        end else begin
            chk("R7 ready", s_ready, 1'b1);
        end
        pstall = m_valid && !m_ready;
        pv = m_valid; pl = m_last; pd = m_data; pid = m_id; pr = m_resp;
        if (m_valid && m_ready && q.size() != 0) void'(q.pop_front());
        if (s_valid && s_ready) begin
            for (int k = 0; k < RATIO; k++) begin
                exp_t e;
                e.data = slice_of(s_data, k); e.id = s_id; e.resp = s_resp;
                e.fin = (k == RATIO - 1); e.last = s_last && e.fin;
                q.push_back(e);
            end
        end
    endtask

    // Drive one cycle of inputs. mode 0 random, 1 always ready, 2 stalled.
    task automatic cycle(int mode);
        @(negedge clk);
        s_valid = ($urandom % 3) != 0;
        s_data  = {$urandom, $urandom};
        s_id    = IW'($urandom);
        s_resp  = 2'($urandom);
        s_last  = 1'($urandom);
        m_ready = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : 1'($urandom % 4 != 0);
        if (mode == 1) s_valid = 1'b1;
        observe();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        pstall = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset valid", m_valid, 1'b0);
        chk("R1 reset last", m_last, 1'b0);
        chk("R1 reset ready", s_ready, 1'b1);
        rst_n = 1'b1;
        // R7: directed corner, back-to-back wide beats with ready held high.
        repeat (40) cycle(1);
        // R8 and R6: long stall while the upstream bus keeps changing.
        repeat (30) cycle(2);
        repeat (2000) cycle(0);
        repeat (20) cycle(1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule